// File: doc/BRIEF.md
# Data Cache Index-Based Maintenance Controller

This block runs maintenance commands against the tag and state array of a 4-way, 256-set write-back data cache. A core issues invalidate, purge or write-back commands. Each command carries a 32-bit operand and a privilege flag. The operand does not name a memory location. It is an address inside a fixed array window: its top byte must be 0xF4, and it selects one line directly through a way field and a set field. No tag comparison is made. A separate flush input looks the cache up by ordinary address, the way a coherency agent would, and asks for the line to be written back if it is dirty.

Whenever a dirty line has to leave the cache, the block rebuilds the line address from the stored tag and the set. It holds that address on a valid/ready write-back port until the port accepts it, and only then changes the line's state. While a write-back is pending the block is busy and refuses new work. A refill path installs lines through a separate install port. Data storage and the external bus belong to other blocks.

Top module: `cache_maint_ctrl`

## Requirements
- R1: For a command, the way is taken from operand bits [14:13] and the set from bits [12:5]. Bits [4:0] have no effect. A write-back address is {stored tag (19 bits), set (8 bits), 5'b0}.
- R2: A privileged command whose operand bits [31:24] differ from 0xF4 changes no line, sends no write-back and raises no error. Command code 3 is reserved and has the same lack of effect in either privilege mode.
- R3: Invalidate (code 0) clears the selected line's valid bit and never sends a write-back, even when the line is dirty.
- R4: Purge (code 1) on a valid dirty line sends a write-back of that line and then invalidates it. On a valid clean line it invalidates the line at once.
- R5: Write-back (code 2) on a valid dirty line sends a write-back of that line and then clears its dirty bit, leaving it valid. On a clean line it does nothing.
- R6: Codes 0 to 2 issued with req_priv low, at any operand, pulse addr_err high for exactly the cycle after acceptance. They change no line and send no write-back.
- R7: A flush whose address (tag bits [31:13], set bits [12:5]) hits a valid dirty line sends a write-back of that line and then clears its dirty bit. A miss or a clean hit does nothing.
- R8: wb_valid stays high with wb_addr unchanged until wb_ready is seen. busy is high from the cycle after acceptance until the cycle after the handshake. The line's state changes at the handshake edge.
- R9: flush_ready is the inverse of busy. req_ready is high only when the block is not busy and no flush is offered, so a flush offered in the same cycle as a command is served first.
- R10: A command on an invalid line sends no write-back and leaves busy low, so a new command can be accepted in the next cycle.
- R11: After reset every line is invalid, and busy, wb_valid and addr_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Maintenance command offered |
| req_ready | output | 1 | Command accepted at this edge if offered |
| req_op | input | 2 | 0 invalidate, 1 purge, 2 write-back, 3 reserved |
| req_addr | input | 32 | Array-window operand |
| req_priv | input | 1 | High for privileged mode |
| flush_valid | input | 1 | Flush lookup offered |
| flush_ready | output | 1 | Flush accepted at this edge if offered |
| flush_addr | input | 32 | Flush lookup address |
| fill_valid | input | 1 | Install a line |
| fill_way | input | 2 | Way to install into |
| fill_addr | input | 32 | Address of the installed line |
| fill_dirty | input | 1 | Installed line starts dirty |
| busy | output | 1 | Write-back pending |
| addr_err | output | 1 | Address-error exception pulse |
| wb_valid | output | 1 | Write-back request valid |
| wb_ready | input | 1 | Write-back request accepted |
| wb_addr | output | 32 | Line address to write back |

## Verification
The assertions rely on a few input rules. The install port never writes a tag that is already present in another way of the same set, so a flush lookup hits at most one way. The install port is also never used while a write-back is pending. The stimulus installs every line while the block is idle, gives each set distinct tags, and drives wb_ready with a random pattern. A held request is therefore seen both stalled and accepted. Array state is observed only through the ports: a later flush or command on the same line shows whether its valid and dirty bits were touched.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
    typedef enum logic [1:0] {
        OP_INV   = 2'd0,
        OP_PURGE = 2'd1,
        OP_WBACK = 2'd2,
        OP_RSVD  = 2'd3
    } maint_op_e;

    typedef enum logic {
        UPD_DROP  = 1'b0,
        UPD_CLEAN = 1'b1
    } upd_kind_e;
endpackage

// File: rtl/cmc_decode.sv
module cmc_decode #(
    parameter int          ADDR_W   = 32,
    parameter int          OFF_W    = 5,
    parameter int          SET_W    = 8,
    parameter int          WAY_W    = 2,
    parameter logic [7:0]  WIN_BYTE = 8'hF4,
    localparam int         TAG_W    = ADDR_W - SET_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_window,
    output logic [WAY_W-1:0]  way,
    output logic [SET_W-1:0]  set,
    output logic [TAG_W-1:0]  tag
);
    always_comb begin
        in_window = (addr[ADDR_W-1 -: 8] == WIN_BYTE);
        way       = addr[OFF_W+SET_W +: WAY_W];
        set       = addr[OFF_W +: SET_W];
        tag       = addr[ADDR_W-1 -: TAG_W];
    end
endmodule

// File: rtl/cmc_tag_array.sv
module cmc_tag_array #(
    parameter int WAYS  = 4,
    parameter int SETS  = 256,
    parameter int TAG_W = 19,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fill_en,
    input  logic [WAY_W-1:0]            fill_way,
    input  logic [SET_W-1:0]            fill_set,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic                        fill_dirty,
    input  logic                        upd_en,
    input  logic [WAY_W-1:0]            upd_way,
    input  logic [SET_W-1:0]            upd_set,
    input  logic                        upd_clr_valid,
    input  logic                        upd_clr_dirty,
    input  logic [WAY_W-1:0]            rd_way,
    input  logic [SET_W-1:0]            rd_set,
    output logic                        rd_valid,
    output logic                        rd_dirty,
    output logic [TAG_W-1:0]            rd_tag,
    input  logic [SET_W-1:0]            lk_set,
    output logic [WAYS-1:0]             lk_valid,
    output logic [WAYS-1:0]             lk_dirty,
    output logic [WAYS-1:0][TAG_W-1:0]  lk_tag
);
    logic [WAYS-1:0][SETS-1:0]             valid_d, valid_q;
    logic [WAYS-1:0][SETS-1:0]             dirty_d, dirty_q;
    logic [WAYS-1:0][SETS-1:0][TAG_W-1:0]  tag_q;

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        if (fill_en) begin
            valid_d[fill_way][fill_set] = 1'b1;
            dirty_d[fill_way][fill_set] = fill_dirty;
        end
        if (upd_en) begin
            if (upd_clr_valid) valid_d[upd_way][upd_set] = 1'b0;
            if (upd_clr_dirty) dirty_d[upd_way][upd_set] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_way][fill_set] <= fill_tag;
    end

    always_comb begin
        rd_valid = valid_q[rd_way][rd_set];
        rd_dirty = dirty_q[rd_way][rd_set];
        rd_tag   = tag_q[rd_way][rd_set];
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_lookup_port
        assign lk_valid[w] = valid_q[w][lk_set];
        assign lk_dirty[w] = dirty_q[w][lk_set];
        assign lk_tag[w]   = tag_q[w][lk_set];
    end

    // R3
    invalidate_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_clr_valid && !(fill_en && fill_way == upd_way && fill_set == upd_set))
        |=> !valid_q[$past(upd_way)][$past(upd_set)]);
endmodule

// File: rtl/cmc_lookup.sv
module cmc_lookup #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 19,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WAYS-1:0]             lk_valid,
    input  logic [WAYS-1:0]             lk_dirty,
    input  logic [WAYS-1:0][TAG_W-1:0]  lk_tag,
    input  logic [TAG_W-1:0]            cmp_tag,
    output logic                        hit,
    output logic                        hit_dirty,
    output logic [WAY_W-1:0]            hit_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = lk_valid[w] && (lk_tag[w] == cmp_tag);
    end

    always_comb begin
        hit       = |match;
        hit_dirty = |(match & lk_dirty);
        hit_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = w[WAY_W-1:0];
        end
    end

    // R7
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/cache_maint_ctrl.sv
module cache_maint_ctrl
    import cmc_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          WAYS       = 4,
    parameter int          SETS       = 256,
    parameter int          LINE_BYTES = 32,
    parameter logic [7:0]  WIN_BYTE   = 8'hF4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_priv,
    input  logic              flush_valid,
    output logic              flush_ready,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              fill_valid,
    input  logic [1:0]        fill_way,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_dirty,
    output logic              busy,
    output logic              addr_err,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;

    typedef struct packed {
        logic              busy;
        upd_kind_e         kind;
        logic [WAY_W-1:0]  way;
        logic [SET_W-1:0]  set;
        logic [ADDR_W-1:0] wb_addr;
        logic              err;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic              m_win, f_win_unused, i_win_unused;
    logic [WAY_W-1:0]  m_way, f_way_unused, i_way_unused;
    logic [SET_W-1:0]  m_set, f_set, i_set;
    logic [TAG_W-1:0]  m_tag_unused, f_tag, i_tag;

    cmc_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W), .WAY_W(WAY_W), .WIN_BYTE(WIN_BYTE))
        u_dec_req (.addr(req_addr), .in_window(m_win), .way(m_way), .set(m_set), .tag(m_tag_unused));
    cmc_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W), .WAY_W(WAY_W), .WIN_BYTE(WIN_BYTE))
        u_dec_flush (.addr(flush_addr), .in_window(f_win_unused), .way(f_way_unused), .set(f_set), .tag(f_tag));
    cmc_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W), .WAY_W(WAY_W), .WIN_BYTE(WIN_BYTE))
        u_dec_fill (.addr(fill_addr), .in_window(i_win_unused), .way(i_way_unused), .set(i_set), .tag(i_tag));

    logic                        rd_valid, rd_dirty;
    logic [TAG_W-1:0]            rd_tag;
    logic [WAYS-1:0]             lk_valid, lk_dirty;
    logic [WAYS-1:0][TAG_W-1:0]  lk_tag;
    logic                        upd_en, upd_clr_valid, upd_clr_dirty;
    logic [WAY_W-1:0]            upd_way;
    logic [SET_W-1:0]            upd_set;

    cmc_tag_array #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_array (
        .clk, .rst_n,
        .fill_en(fill_valid), .fill_way(fill_way[WAY_W-1:0]), .fill_set(i_set),
        .fill_tag(i_tag), .fill_dirty(fill_dirty),
        .upd_en, .upd_way, .upd_set, .upd_clr_valid, .upd_clr_dirty,
        .rd_way(m_way), .rd_set(m_set), .rd_valid, .rd_dirty, .rd_tag,
        .lk_set(f_set), .lk_valid, .lk_dirty, .lk_tag
    );

    logic             f_hit, f_hit_dirty;
    logic [WAY_W-1:0] f_hit_way;

    cmc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
        .clk, .rst_n, .lk_valid, .lk_dirty, .lk_tag, .cmp_tag(f_tag),
        .hit(f_hit), .hit_dirty(f_hit_dirty), .hit_way(f_hit_way)
    );

    logic      req_fire, flush_fire;
    maint_op_e op;

    always_comb begin
        flush_ready = !st_q.busy;
        req_ready   = !st_q.busy && !flush_valid;
        flush_fire  = flush_valid && flush_ready;
        req_fire    = req_valid && req_ready;
        op          = maint_op_e'(req_op);

        st_d          = st_q;
        st_d.err      = 1'b0;
        upd_en        = 1'b0;
        upd_clr_valid = 1'b0;
        upd_clr_dirty = 1'b0;
        upd_way       = m_way;
        upd_set       = m_set;

        if (st_q.busy) begin
            if (wb_ready) begin
                upd_en        = 1'b1;
                upd_way       = st_q.way;
                upd_set       = st_q.set;
                upd_clr_valid = (st_q.kind == UPD_DROP);
                upd_clr_dirty = 1'b1;
                st_d.busy     = 1'b0;
            end
        end else if (flush_fire) begin
            if (f_hit && f_hit_dirty) begin
                st_d.busy    = 1'b1;
                st_d.kind    = UPD_CLEAN;
                st_d.way     = f_hit_way;
                st_d.set     = f_set;
                st_d.wb_addr = {f_tag, f_set, {OFF_W{1'b0}}};
            end
        end else if (req_fire && op != OP_RSVD) begin
            if (!req_priv) begin
                st_d.err = 1'b1;
            end else if (m_win) begin
                unique case (op)
                    OP_INV: begin
                        upd_en        = 1'b1;
                        upd_clr_valid = 1'b1;
                        upd_clr_dirty = 1'b1;
                    end
                    OP_PURGE, OP_WBACK: begin
                        if (rd_valid && rd_dirty) begin
                            st_d.busy    = 1'b1;
                            st_d.kind    = (op == OP_PURGE) ? UPD_DROP : UPD_CLEAN;
                            st_d.way     = m_way;
                            st_d.set     = m_set;
                            st_d.wb_addr = {rd_tag, m_set, {OFF_W{1'b0}}};
                        end else if (rd_valid && op == OP_PURGE) begin
                            upd_en        = 1'b1;
                            upd_clr_valid = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign wb_valid = st_q.busy;
    assign wb_addr  = st_q.wb_addr;
    assign addr_err = st_q.err;

    // R8
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));

    // R6
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> $past(req_valid && req_ready && !req_priv && req_op != 2'd3));

    // R3
    inv_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 2'd0) |=> !wb_valid);

    // R9
    wb_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_valid) |-> $past(flush_valid || (req_valid && req_priv)));
endmodule

// File: tb/cache_maint_ctrl_bench.sv
`timescale 1ns/1ps
module cache_maint_ctrl_bench;
    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, req_priv = 0, flush_valid = 0, fill_valid = 0, fill_dirty = 0;
    logic [1:0]  req_op = 0, fill_way = 0;
    logic [31:0] req_addr = 0, flush_addr = 0, fill_addr = 0;
    logic        req_ready, flush_ready, busy, addr_err, wb_valid, wb_addr_ok;
    logic        wb_ready = 0;
    logic [31:0] wb_addr;

    int errors = 0, checks = 0;
    logic [31:0] exp_q[$];
    bit          done = 0;

    always #2 clk = ~clk;

    cache_maint_ctrl u_cache_maint_ctrl (
        .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_addr, .req_priv,
        .flush_valid, .flush_ready, .flush_addr, .fill_valid, .fill_way,
        .fill_addr, .fill_dirty, .busy, .addr_err, .wb_valid, .wb_ready, .wb_addr
    );

    assign wb_addr_ok = 1'b1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] line(input logic [18:0] tag, input logic [7:0] set);
        return {tag, set, 5'b0};
    endfunction

    function automatic logic [31:0] win(input logic [1:0] way, input logic [7:0] set, input logic [4:0] off);
        return {8'hF4, 9'h0, way, set, off};
    endfunction

    // Random write-back acceptance.
    initial forever begin
        @(posedge clk); #1;
        wb_ready = ($urandom % 3) != 0;
    end

    // Monitor: pops expected write-backs and checks the hold rule.
    logic        prev_stall = 0;
    logic [31:0] prev_addr = 0;
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (prev_stall) chk(wb_valid && wb_addr == prev_addr, "R8 held request", wb_addr, prev_addr);
            if (wb_valid && wb_ready) begin
                if (exp_q.size() == 0) chk(1'b0, "R3/R10 unexpected write-back", wb_addr, 32'h0);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(wb_addr == e, "R1 write-back address", wb_addr, e);
                end
            end
            prev_stall = wb_valid && !wb_ready;
            prev_addr  = wb_addr;
        end
    end

    task automatic wait_idle(input string req);
        while (busy) @(negedge clk);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic install(input logic [1:0] way, input logic [18:0] tag, input logic [7:0] set, input bit dirty);
        @(posedge clk); #1;
        fill_valid = 1; fill_way = way; fill_addr = line(tag, set) | 32'h11; fill_dirty = dirty;
        @(posedge clk); #1;
        fill_valid = 0;
    endtask

    task automatic maint(input logic [1:0] op, input logic [31:0] addr, input bit priv,
                         input bit exp_err, input bit exp_busy, input string req);
        @(posedge clk); #1;
        req_valid = 1; req_op = op; req_addr = addr; req_priv = priv;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 0;
        @(negedge clk);
        chk(addr_err == exp_err, req, addr_err, exp_err);
        chk(busy == exp_busy, req, busy, exp_busy);
        if (exp_busy) chk(!req_ready && !flush_ready, "R9 blocked while busy", req_ready, 0);
        @(negedge clk);
        chk(addr_err == 0, "R6 single-cycle error pulse", addr_err, 0);
        wait_idle(req);
    endtask

    task automatic flush(input logic [31:0] addr, input string req);
        @(posedge clk); #1;
        flush_valid = 1; flush_addr = addr;
        do @(negedge clk); while (!flush_ready);
        @(posedge clk); #1;
        flush_valid = 0;
        @(negedge clk);
        wait_idle(req);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(!busy && !wb_valid && !addr_err, "R11 reset outputs", {busy, wb_valid, addr_err}, 0);
        chk(req_ready && flush_ready, "R11 ready after reset", {req_ready, flush_ready}, 2'b11);
        flush(line(19'h1234, 8'd5), "R11 empty cache after reset");

        install(2'd0, 19'h0AAAA, 8'd5,   1);
        install(2'd1, 19'h0BBBB, 8'd5,   0);
        install(2'd2, 19'h0CCCC, 8'd9,   1);
        install(2'd3, 19'h0DDDD, 8'd200, 1);
        install(2'd1, 19'h0EEEE, 8'd255, 1);
        install(2'd3, 19'h0FFFF, 8'd0,   1);
        install(2'd2, 19'h12345, 8'h7F,  1);

        // R3 invalidate dirty line: no write-back, then gone
        maint(2'd0, win(2'd0, 8'd5, 5'h1F), 1, 0, 0, "R3 invalidate dirty");
        flush(line(19'h0AAAA, 8'd5), "R3 line invalid after invalidate");

        // R4 purge dirty then clean
        exp_q.push_back(line(19'h0CCCC, 8'd9));
        maint(2'd1, win(2'd2, 8'd9, 5'h00), 1, 0, 1, "R4 purge dirty");
        maint(2'd1, win(2'd2, 8'd9, 5'h00), 1, 0, 0, "R10 purge invalid line");
        flush(line(19'h0CCCC, 8'd9), "R4 line gone after purge");

        // R5 write-back keeps line, clears dirty
        exp_q.push_back(line(19'h0DDDD, 8'd200));
        maint(2'd2, win(2'd3, 8'd200, 5'h04), 1, 0, 1, "R5 write-back dirty");
        flush(line(19'h0DDDD, 8'd200), "R5 dirty cleared");
        maint(2'd2, win(2'd3, 8'd200, 5'h04), 1, 0, 0, "R5 write-back clean");

        // R6 user mode
        maint(2'd0, win(2'd1, 8'd255, 5'h0), 0, 1, 0, "R6 user invalidate");
        maint(2'd1, 32'h1234_5678, 0, 1, 0, "R6 user purge outside window");
        maint(2'd2, win(2'd1, 8'd255, 5'h0), 0, 1, 0, "R6 user write-back");
        exp_q.push_back(line(19'h0EEEE, 8'd255));
        flush(line(19'h0EEEE, 8'd255) | 32'h7, "R7 dirty hit, R6 line untouched");
        flush(line(19'h0EEEE, 8'd255), "R7 dirty cleared after flush");

        // R2 outside window and reserved code
        maint(2'd1, {8'hF5, 9'h0, 2'd3, 8'd0, 5'h0}, 1, 0, 0, "R2 window byte F5");
        maint(2'd0, {8'hF0, 9'h0, 2'd3, 8'd0, 5'h0}, 1, 0, 0, "R2 window byte F0");
        maint(2'd3, win(2'd3, 8'd0, 5'h0), 1, 0, 0, "R2 reserved code privileged");
        maint(2'd3, win(2'd3, 8'd0, 5'h0), 0, 0, 0, "R2 reserved code user");
        exp_q.push_back(line(19'h0FFFF, 8'd0));
        flush(line(19'h0FFFF, 8'd0), "R2 line still dirty");

        // R7 clean hit and miss
        flush(line(19'h0BBBB, 8'd5), "R7 clean hit");
        flush(line(19'h7ABCD, 8'd5), "R7 miss");

        // R1 decode with offset bits set
        exp_q.push_back(line(19'h12345, 8'h7F));
        maint(2'd2, win(2'd2, 8'h7F, 5'h1F), 1, 0, 1, "R1 decode way/set");

        // R9 flush and command in the same cycle
        install(2'd0, 19'h01111, 8'd3, 1);
        install(2'd1, 19'h02222, 8'd4, 1);
        exp_q.push_back(line(19'h01111, 8'd3));
        exp_q.push_back(line(19'h02222, 8'd4));
        @(posedge clk); #1;
        flush_valid = 1; flush_addr = line(19'h01111, 8'd3);
        req_valid = 1; req_op = 2'd2; req_addr = win(2'd1, 8'd4, 5'h0); req_priv = 1;
        @(negedge clk);
        chk(!req_ready && flush_ready, "R9 flush wins arbitration", {req_ready, flush_ready}, 2'b01);
        @(posedge clk); #1;
        flush_valid = 0;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 0;
        @(negedge clk);
        wait_idle("R9 both write-backs in order");

        repeat (4) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule